// File: doc/BRIEF.md
# I2C SCL Clock Generator

This block produces the serial clock of an I2C master from a fast peripheral clock. It drives the SCL line low through an open-drain style output, `scl_drive_low`. It reads the line back on `scl_in`. Three timing modes are supported. Standard mode gives equal low and high times. Fast mode has two variants: one with a 2:1 low-to-high ratio and one with a 16:9 ratio. A divider register input gives the length of one timing unit in peripheral clock cycles, and the mode inputs choose how many units each half-period lasts.

After the generator releases SCL, it starts timing the high half only once it samples the line high. A slave that holds SCL low therefore lengthens the low half and leaves the high half unchanged. A rise-time budget gives the number of release cycles the generator tolerates as a slow rising edge. Past that budget it reports that the slave is stretching the clock. Two one-cycle strobes tell a byte-level engine when SCL has just been pulled low and when it has just been seen high.

A separate combinational helper turns a peripheral frequency and a target bus speed into the register values: the divider, the mode bits, the rise-time count and the peripheral frequency in whole MHz. Software or a wrapper can load these values into the generator's inputs.

Top module: `scl_clock_gen`

## Requirements
- R1: While `enable` is low, and on the first cycle after `enable` is sampled low, `scl_drive_low`, `low_stb`, `high_stb` and `stretching` are all 0. The same holds during synchronous reset, whatever the value of `enable`.
- R2: In standard mode (`fast_i`=0), SCL is driven low for exactly D cycles. It stays high for exactly D cycles, counted from the first cycle the line is seen high. D is the effective divider.
- R3: In fast mode with `duty169_i`=0, the low half lasts 2·D cycles and the high half lasts D cycles.
- R4: In fast mode with `duty169_i`=1, the low half lasts 16·D cycles and the high half lasts 9·D cycles.
- R5: The effective divider D is `div_i`, raised to 4 in standard mode when `div_i` is below 4, and raised to 1 in fast mode when `div_i` is 0.
- R6: Once released, the generator waits while `scl_in` stays low. That wait adds to the low time seen on the line, and the following high half keeps its nominal length.
- R7: `stretching` is 1 only in release cycles where `scl_in` is low and at least `rise_i` earlier release cycles have already seen the line low. A slave hold of S release cycles therefore gives max(0, S − `rise_i`) stretching cycles.
- R8: `low_stb` is 1 exactly in the first cycle of each driven-low half. `high_stb` is 1 exactly in the first cycle the released line is seen high. The two are never 1 together.
- R9: The helper selects standard mode for target speeds of 100000 Hz or less, with `calc_fast`=0. There the divider is pclk/(2·speed), rounded down, with a minimum of 4 and saturating at 2^DIV_W−1. The rise count is the peripheral frequency in MHz plus one, saturated at 63.
- R10: The helper selects fast mode above 100000 Hz, with `calc_fast`=1. The divider is pclk/(3·speed) for the 2:1 ratio, or pclk/(25·speed) with `calc_duty_flag`=1 for 16:9. A zero result becomes 1. The rise count is (MHz·300)/1000 + 1, using the saturated MHz value.
- R11: `calc_freq_mhz` is pclk/1000000, saturated at 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Runs the generator; low releases SCL and clears all counters |
| div_i | input | DIV_W | Divider: length of one timing unit in clock cycles |
| fast_i | input | 1 | 1 selects fast mode |
| duty169_i | input | 1 | In fast mode, 1 selects the 16:9 ratio, 0 the 2:1 ratio |
| rise_i | input | CFG_W | Release cycles tolerated before a low line counts as stretching |
| scl_in | input | 1 | Sampled level of the SCL line |
| scl_drive_low | output | 1 | 1 pulls SCL low; 0 releases it |
| low_stb | output | 1 | First cycle of each driven-low half |
| high_stb | output | 1 | First cycle the released line is seen high |
| stretching | output | 1 | A slave is holding SCL low beyond the rise budget |
| calc_pclk_hz | input | HZ_W | Helper: peripheral clock frequency in Hz |
| calc_target_hz | input | HZ_W | Helper: target SCL frequency in Hz |
| calc_duty169 | input | 1 | Helper: request the 16:9 ratio when in fast mode |
| calc_div | output | DIV_W | Helper: computed divider |
| calc_fast | output | 1 | Helper: fast mode selected |
| calc_duty_flag | output | 1 | Helper: 16:9 ratio in effect |
| calc_rise | output | CFG_W | Helper: rise-time count |
| calc_freq_mhz | output | CFG_W | Helper: peripheral frequency in MHz, saturated |

## Verification
The bench builds the block with its defaults: DIV_W=12, CFG_W=6, HZ_W=32 and a 100000 Hz mode limit. With these widths, a 100 MHz peripheral clock saturates both 6-bit fields at 63. A 10 kHz target from that clock pushes the divider past 4095, so both saturation paths are reached with realistic frequencies. The 100000/100001 Hz pair tests the mode boundary. Generator runs use dividers from 0 to 7, which keeps the phases short. Even so, every mode, both minimum clamps, the single-cycle high half, and slave holds shorter and longer than the rise budget all appear within a few hundred cycles.

// File: rtl/scl_gen_pkg.sv
// Shared types and constants for the SCL clock generator.
// Assumes: nothing beyond IEEE 1800-2017.
package scl_gen_pkg;

    // Phase of the SCL waveform as seen by the generator
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_REL  = 2'd2,
        PH_HIGH = 2'd3
    } scl_phase_e;

    // Minimum effective divider per mode
    localparam int unsigned STD_MIN_DIV  = 4;
    localparam int unsigned FAST_MIN_DIV = 1;

    // Divider units per half-period in each fast ratio
    localparam int unsigned R21_LOW_UNITS  = 2;
    localparam int unsigned R21_HIGH_UNITS = 1;
    localparam int unsigned R169_LOW_UNITS  = 16;
    localparam int unsigned R169_HIGH_UNITS = 9;

    // Helper divisor multipliers per mode
    localparam int unsigned STD_SPEED_MUL  = 2;
    localparam int unsigned R21_SPEED_MUL  = 3;
    localparam int unsigned R169_SPEED_MUL = 25;

endpackage

// File: rtl/scl_cfg_calc.sv
// Configuration helper: derives divider, mode bits, rise-time count and
// peripheral MHz from a peripheral frequency and a target bus speed.
// Assumes: purely combinational; inputs in Hz; a target of 0 gives the
// largest divider.
module scl_cfg_calc
    import scl_gen_pkg::*;
#(
    parameter int DIV_W        = 12,
    parameter int CFG_W        = 6,
    parameter int HZ_W         = 32,
    parameter int STD_LIMIT_HZ = 100000
) (
    input  logic [HZ_W-1:0]  pclk_hz,
    input  logic [HZ_W-1:0]  target_hz,
    input  logic             duty169_req,
    output logic [DIV_W-1:0] div_o,
    output logic             fast_o,
    output logic             duty_o,
    output logic [CFG_W-1:0] rise_o,
    output logic [CFG_W-1:0] mhz_o
);
    localparam int WW        = HZ_W + 6;
    localparam int CFG_MAX   = (1 << CFG_W) - 1;
    localparam int DIV_MAX   = (1 << DIV_W) - 1;

    logic [HZ_W-1:0] mhz_raw;
    logic [WW-1:0]   denom;
    logic [WW-1:0]   quot;

    // Frequency field and mode selection
    always_comb begin
        mhz_raw = pclk_hz / HZ_W'(1000000);
        mhz_o   = (mhz_raw > HZ_W'(CFG_MAX)) ? CFG_W'(CFG_MAX) : mhz_raw[CFG_W-1:0];
        fast_o  = (target_hz > HZ_W'(STD_LIMIT_HZ));
        duty_o  = fast_o & duty169_req;
    end

    // Divider: mode-specific divisor, then clamps and saturation
    always_comb begin
        if (!fast_o)
            denom = WW'(target_hz) * WW'(STD_SPEED_MUL);
        else if (duty169_req)
            denom = WW'(target_hz) * WW'(R169_SPEED_MUL);
        else
            denom = WW'(target_hz) * WW'(R21_SPEED_MUL);

        if (denom == '0)
            quot = '1;
        else
            quot = WW'(pclk_hz) / denom;

        if (!fast_o && quot < WW'(STD_MIN_DIV))
            div_o = DIV_W'(STD_MIN_DIV);
        else if (fast_o && quot == '0)
            div_o = DIV_W'(FAST_MIN_DIV);
        else if (quot > WW'(DIV_MAX))
            div_o = DIV_W'(DIV_MAX);
        else
            div_o = quot[DIV_W-1:0];
    end

    // Rise-time budget: 1000 ns in standard mode, 300 ns in fast mode
    always_comb begin
        if (!fast_o) begin
            if (mhz_raw >= HZ_W'(CFG_MAX - 1))
                rise_o = CFG_W'(CFG_MAX);
            else
                rise_o = mhz_raw[CFG_W-1:0] + CFG_W'(1);
        end else begin
            rise_o = CFG_W'((32'(mhz_o) * 32'd300) / 32'd1000 + 32'd1);
        end
    end

endmodule

// File: rtl/scl_phase_len.sv
// Phase length decoder: turns the divider and mode bits into the low and
// high half-period lengths in clock cycles, applying per-mode clamps.
// Assumes: configuration is held steady while the generator runs.
module scl_phase_len
    import scl_gen_pkg::*;
#(
    parameter int DIV_W = 12,
    parameter int PH_W  = DIV_W + 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic             fast_i,
    input  logic             duty169_i,
    output logic [PH_W-1:0]  low_len,
    output logic [PH_W-1:0]  high_len
);
    logic [DIV_W-1:0] eff_div;

    // Per-mode minimum clamp on the divider
    always_comb begin
        if (!fast_i)
            eff_div = (div_i < DIV_W'(STD_MIN_DIV)) ? DIV_W'(STD_MIN_DIV) : div_i;
        else
            eff_div = (div_i == '0) ? DIV_W'(FAST_MIN_DIV) : div_i;
    end

    // Scale the unit into half-period lengths for the selected ratio
    always_comb begin
        if (!fast_i) begin
            low_len  = PH_W'(eff_div);
            high_len = PH_W'(eff_div);
        end else if (duty169_i) begin
            low_len  = PH_W'(eff_div) * PH_W'(R169_LOW_UNITS);
            high_len = PH_W'(eff_div) * PH_W'(R169_HIGH_UNITS);
        end else begin
            low_len  = PH_W'(eff_div) * PH_W'(R21_LOW_UNITS);
            high_len = PH_W'(eff_div) * PH_W'(R21_HIGH_UNITS);
        end
    end

    // Standard mode is symmetric and never shorter than the minimum
    assert_std_symmetric_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !fast_i |-> (low_len == high_len) && (high_len >= PH_W'(STD_MIN_DIV)));

    // 2:1 ratio holds between the two halves
    assert_ratio_21_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_i && !duty169_i) |-> (low_len == (high_len << 1)));

    // 16:9 ratio holds between the two halves
    assert_ratio_169_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_i && duty169_i) |-> ((low_len * 9) == (high_len * 16)));

    // Fast mode never yields an empty high half
    assert_fast_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fast_i |-> (high_len != '0));

endmodule

// File: rtl/scl_phase_fsm.sv
// SCL phase sequencer: drives the line low for the low length, releases it,
// waits for the line to read high (flagging stretching past the rise
// budget), then times the high length and repeats.
// Assumes: scl_in is already synchronous to clk; low_len and high_len >= 1.
module scl_phase_fsm
    import scl_gen_pkg::*;
#(
    parameter int PH_W  = 17,
    parameter int CFG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [PH_W-1:0]  low_len,
    input  logic [PH_W-1:0]  high_len,
    input  logic [CFG_W-1:0] rise_i,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             low_stb,
    output logic             high_stb,
    output logic             stretching
);
    scl_phase_e       state_q;
    logic [PH_W-1:0]  cnt_q;
    logic [CFG_W-1:0] wait_q;
    logic [PH_W-1:0]  low_run_q;

    // Phase sequencing, half-period counting and release wait counting
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
            wait_q  <= '0;
            low_stb <= 1'b0;
        end else begin
            low_stb <= 1'b0;
            case (state_q)
                PH_IDLE: begin
                    state_q <= PH_LOW;
                    cnt_q   <= PH_W'(1);
                    low_stb <= 1'b1;
                end
                PH_LOW: begin
                    if (cnt_q >= low_len) begin
                        state_q <= PH_REL;
                        cnt_q   <= '0;
                        wait_q  <= '0;
                    end else begin
                        cnt_q <= cnt_q + PH_W'(1);
                    end
                end
                PH_REL: begin
                    if (scl_in) begin
                        if (high_len <= PH_W'(1)) begin
                            state_q <= PH_LOW;
                            cnt_q   <= PH_W'(1);
                            low_stb <= 1'b1;
                        end else begin
                            state_q <= PH_HIGH;
                            cnt_q   <= PH_W'(2);
                        end
                    end else if (wait_q != '1) begin
                        wait_q <= wait_q + CFG_W'(1);
                    end
                end
                PH_HIGH: begin
                    if (cnt_q >= high_len) begin
                        state_q <= PH_LOW;
                        cnt_q   <= PH_W'(1);
                        low_stb <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + PH_W'(1);
                    end
                end
                default: state_q <= PH_IDLE;
            endcase
        end
    end

    // Output decode from the phase register and the sampled line
    always_comb begin
        scl_drive_low = (state_q == PH_LOW);
        high_stb      = (state_q == PH_REL) && scl_in;
        stretching    = (state_q == PH_REL) && !scl_in && (wait_q >= rise_i);
    end

    // Checker counter: length of the current driven-low run
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_run_q <= '0;
        else if (scl_drive_low)
            low_run_q <= low_run_q + PH_W'(1);
        else
            low_run_q <= '0;
    end

    // A disable is seen by the line within one cycle
    assert_release_on_disable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!scl_drive_low && !low_stb && !stretching));

    // Each driven-low run that ends normally lasts the programmed length
    assert_low_run_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(scl_drive_low) && $past(enable)) |-> (low_run_q == $past(low_len)));

    // Stretching is only reported on a released line that reads low
    assert_stretch_line_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stretching |-> (!scl_drive_low && !scl_in));

    // Strobes are exclusive and match the line state
    assert_strobes_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({low_stb, high_stb}));

    assert_low_stb_driven_R8: assert property (@(posedge clk) disable iff (!rst_n)
        low_stb |-> scl_drive_low);

    // High timing only begins on a released line seen high
    assert_high_stb_sampled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        high_stb |-> (scl_in && !scl_drive_low));

endmodule

// File: rtl/scl_clock_gen.sv
// I2C SCL clock generator top: phase length decoder feeding the phase
// sequencer, plus the standalone configuration helper.
// Assumes: div_i, fast_i, duty169_i and rise_i are stable while enable is
// high; scl_in is synchronised outside this block.
module scl_clock_gen
    import scl_gen_pkg::*;
#(
    parameter int DIV_W        = 12,
    parameter int CFG_W        = 6,
    parameter int HZ_W         = 32,
    parameter int STD_LIMIT_HZ = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] div_i,
    input  logic             fast_i,
    input  logic             duty169_i,
    input  logic [CFG_W-1:0] rise_i,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             low_stb,
    output logic             high_stb,
    output logic             stretching,
    input  logic [HZ_W-1:0]  calc_pclk_hz,
    input  logic [HZ_W-1:0]  calc_target_hz,
    input  logic             calc_duty169,
    output logic [DIV_W-1:0] calc_div,
    output logic             calc_fast,
    output logic             calc_duty_flag,
    output logic [CFG_W-1:0] calc_rise,
    output logic [CFG_W-1:0] calc_freq_mhz
);
    localparam int PH_W = DIV_W + 5;

    logic [PH_W-1:0] low_len;
    logic [PH_W-1:0] high_len;

    scl_phase_len #(
        .DIV_W (DIV_W),
        .PH_W  (PH_W)
    ) u_len (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_i     (div_i),
        .fast_i    (fast_i),
        .duty169_i (duty169_i),
        .low_len   (low_len),
        .high_len  (high_len)
    );

    scl_phase_fsm #(
        .PH_W  (PH_W),
        .CFG_W (CFG_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .low_len       (low_len),
        .high_len      (high_len),
        .rise_i        (rise_i),
        .scl_in        (scl_in),
        .scl_drive_low (scl_drive_low),
        .low_stb       (low_stb),
        .high_stb      (high_stb),
        .stretching    (stretching)
    );

    scl_cfg_calc #(
        .DIV_W        (DIV_W),
        .CFG_W        (CFG_W),
        .HZ_W         (HZ_W),
        .STD_LIMIT_HZ (STD_LIMIT_HZ)
    ) u_calc (
        .pclk_hz     (calc_pclk_hz),
        .target_hz   (calc_target_hz),
        .duty169_req (calc_duty169),
        .div_o       (calc_div),
        .fast_o      (calc_fast),
        .duty_o      (calc_duty_flag),
        .rise_o      (calc_rise),
        .mhz_o       (calc_freq_mhz)
    );

endmodule

// File: tb/scl_clock_gen_bench.sv
// Scoreboard bench: driver tasks queue the expected SCL half-periods, a
// monitor measures the line and compares each completed half-period.
module scl_clock_gen_bench;
    localparam int DIV_W = 12;
    localparam int CFG_W = 6;
    localparam int HZ_W  = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic [DIV_W-1:0] div_i = '0;
    logic             fast_i = 1'b0;
    logic             duty169_i = 1'b0;
    logic [CFG_W-1:0] rise_i = '0;
    logic             scl_in;
    logic             scl_drive_low, low_stb, high_stb, stretching;
    logic [HZ_W-1:0]  calc_pclk_hz = '0;
    logic [HZ_W-1:0]  calc_target_hz = '0;
    logic             calc_duty169 = 1'b0;
    logic [DIV_W-1:0] calc_div;
    logic             calc_fast, calc_duty_flag;
    logic [CFG_W-1:0] calc_rise, calc_freq_mhz;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Slave model: holds the line low for hold_s release cycles
    int hold_s = 0;
    int hold_rem = 0;
    assign scl_in = !scl_drive_low && (hold_rem == 0);

    // Scoreboard queues
    int    q_lvl[$];
    int    q_len[$];
    int    q_st[$];
    string q_req[$];

    // Monitor state
    bit mon_en = 0;
    bit armed = 0;
    int cur_lvl = 0;
    int cur_len = 0;
    int cur_st = 0;
    int strobe_err = 0;

    always #10 clk = ~clk;

    scl_clock_gen u_scl_clock_gen (
        .clk            (clk),
        .rst_n          (rst_n),
        .enable         (enable),
        .div_i          (div_i),
        .fast_i         (fast_i),
        .duty169_i      (duty169_i),
        .rise_i         (rise_i),
        .scl_in         (scl_in),
        .scl_drive_low  (scl_drive_low),
        .low_stb        (low_stb),
        .high_stb       (high_stb),
        .stretching     (stretching),
        .calc_pclk_hz   (calc_pclk_hz),
        .calc_target_hz (calc_target_hz),
        .calc_duty169   (calc_duty169),
        .calc_div       (calc_div),
        .calc_fast      (calc_fast),
        .calc_duty_flag (calc_duty_flag),
        .calc_rise      (calc_rise),
        .calc_freq_mhz  (calc_freq_mhz)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Slave hold update, just after each rising edge
    always @(posedge clk) begin
        #1;
        if (scl_drive_low) hold_rem = hold_s + 1;
        else if (hold_rem > 0) hold_rem = hold_rem - 1;
    end

    // Pop the oldest expected half-period and compare it to a measured one
    task automatic score(input int lvl, input int len, input int st);
        if (q_len.size() != 0) begin
            int    e_lvl = q_lvl.pop_front();
            int    e_len = q_len.pop_front();
            int    e_st  = q_st.pop_front();
            string e_req = q_req.pop_front();
            check(lvl == e_lvl, e_req, "half level", lvl, e_lvl);
            check(len == e_len, e_req, lvl ? "high length" : "low length", len, e_len);
            check(st == e_st, (lvl == 0) ? "R7" : e_req, "stretch cycles", st, e_st);
        end
    endtask

    // Monitor: mid-cycle sampling of the line, strobes and stretch flag
    always @(posedge clk) begin
        #5;
        if (!mon_en) begin
            armed = 0;
        end else if (!armed) begin
            if (!scl_in) begin
                armed = 1; cur_lvl = 0; cur_len = 1; cur_st = int'(stretching);
                if (!(low_stb && !high_stb)) strobe_err++;
            end
        end else if (int'(scl_in) == cur_lvl) begin
            cur_len++;
            cur_st += int'(stretching);
            if (low_stb || high_stb) strobe_err++;
        end else begin
            score(cur_lvl, cur_len, cur_st);
            cur_lvl = int'(scl_in); cur_len = 1; cur_st = int'(stretching);
            if (scl_in) begin
                if (!(high_stb && !low_stb)) strobe_err++;
            end else begin
                if (!(low_stb && !high_stb)) strobe_err++;
            end
        end
    end

    // Driver: queue expected halves, run the generator until drained
    task automatic run_case(input string req, input int dv, input bit fm, input bit d169,
                            input int rise, input int hold, input int pairs,
                            input int lo_exp, input int hi_exp);
        int st_exp = (hold > rise) ? hold - rise : 0;
        int base_err = strobe_err;
        @(negedge clk);
        div_i = DIV_W'(dv); fast_i = fm; duty169_i = d169;
        rise_i = CFG_W'(rise); hold_s = hold;
        for (int i = 0; i < pairs; i++) begin
            q_lvl.push_back(0); q_len.push_back(lo_exp + hold); q_st.push_back(st_exp); q_req.push_back(req);
            q_lvl.push_back(1); q_len.push_back(hi_exp); q_st.push_back(0); q_req.push_back(req);
        end
        mon_en = 1;
        enable = 1;
        for (int c = 0; c < 5000 && q_len.size() != 0; c++) @(negedge clk);
        check(q_len.size() == 0, req, "queue drained", q_len.size(), 0);
        enable = 0;
        mon_en = 0;
        check(strobe_err == base_err, "R8", "strobe errors", strobe_err - base_err, 0);
        @(posedge clk); #5;
        check(!scl_drive_low && !low_stb && !high_stb && !stretching, "R1",
              "idle after disable", {scl_drive_low, low_stb, high_stb, stretching}, 0);
        q_lvl.delete(); q_len.delete(); q_st.delete(); q_req.delete();
        repeat (hold + 3) @(negedge clk);
    endtask

    task automatic calc_case(input string req, input int pclk, input int tgt, input bit d169,
                             input int e_div, input bit e_fast, input bit e_duty,
                             input int e_rise, input int e_mhz);
        @(negedge clk);
        calc_pclk_hz = HZ_W'(pclk); calc_target_hz = HZ_W'(tgt); calc_duty169 = d169;
        #2;
        check(int'(calc_div) == e_div, req, "divider", calc_div, e_div);
        check(calc_fast == e_fast && calc_duty_flag == e_duty, req, "mode bits",
              {calc_fast, calc_duty_flag}, {e_fast, e_duty});
        check(int'(calc_rise) == e_rise, req, "rise count", calc_rise, e_rise);
        check(int'(calc_freq_mhz) == e_mhz, "R11", "freq MHz", calc_freq_mhz, e_mhz);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Main sequence
    initial begin
        // R1: reset holds the line released even with enable high
        enable = 1;
        repeat (3) @(negedge clk);
        check(!scl_drive_low && !low_stb && !high_stb && !stretching, "R1",
              "reset state", {scl_drive_low, low_stb, high_stb, stretching}, 0);
        enable = 0;
        rst_n = 1;
        repeat (2) @(negedge clk);
        check(!scl_drive_low && scl_in, "R1", "idle after reset", scl_drive_low, 0);

        // Helper: R9 standard, R10 fast, R11 saturation
        calc_case("R9",  42000000, 100000, 0, 210, 0, 0, 43, 42);
        calc_case("R9",  500000,   100000, 0, 4,   0, 0, 1,  0);
        calc_case("R9",  100000000, 10000, 0, 4095, 0, 0, 63, 63);
        calc_case("R9",  100000000, 100000, 0, 500, 0, 0, 63, 63);
        calc_case("R10", 42000000, 100001, 0, 139, 1, 0, 13, 42);
        calc_case("R10", 42000000, 400000, 0, 35,  1, 0, 13, 42);
        calc_case("R10", 42000000, 400000, 1, 4,   1, 1, 13, 42);
        calc_case("R10", 1000000,  400000, 1, 1,   1, 1, 1,  1);
        calc_case("R10", 100000000, 400000, 0, 83, 1, 0, 19, 63);

        // Generator modes
        run_case("R2", 5, 0, 0, 3, 0, 3, 5, 5);
        run_case("R5", 2, 0, 0, 3, 0, 2, 4, 4);
        run_case("R5", 0, 0, 0, 3, 0, 2, 4, 4);
        run_case("R3", 3, 1, 0, 3, 0, 3, 6, 3);
        run_case("R5", 0, 1, 0, 3, 0, 3, 2, 1);
        run_case("R4", 1, 1, 1, 3, 0, 2, 16, 9);
        run_case("R5", 0, 1, 1, 3, 0, 2, 16, 9);
        // Stretching: R6 lengthened low, nominal high; R7 budget
        run_case("R6", 6, 0, 0, 2, 4, 3, 6, 6);
        run_case("R7", 7, 0, 0, 5, 3, 2, 7, 7);
        run_case("R6", 2, 1, 1, 0, 2, 2, 32, 18);

        // R1: disable in the middle of a low half
        @(negedge clk);
        div_i = DIV_W'(8); fast_i = 0; duty169_i = 0; hold_s = 0;
        enable = 1;
        repeat (3) @(negedge clk);
        check(scl_drive_low, "R1", "driving before disable", scl_drive_low, 1);
        enable = 0;
        @(posedge clk); #5;
        check(!scl_drive_low && !low_stb, "R1", "released on disable", scl_drive_low, 0);
        repeat (10) @(negedge clk);
        check(!scl_drive_low && !stretching && !high_stb, "R1", "stays released",
              {scl_drive_low, stretching, high_stb}, 0);

        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule